// File: doc/BRIEF.md
# SIMD Lane Unzip Permute Unit

This unit separates the lanes of a pair of SIMD operands into two streams. The two operands are joined into one working value, with the second operand on top and the first operand underneath. The unit returns every even-numbered element of that value on one result port and every odd-numbered element on the other. Lanes may be 8, 16 or 32 bits wide. The registers may be 64 or 128 bits wide. All lanes are treated as raw bits, and no condition state is produced.

An execute stage presents both operands, a size code, a width mode bit and a same-register flag together with `in_valid`. One cycle later the results appear with `out_valid`. Two input cases have no architectural result: both operands naming the same register, and the reserved size code. In both cases the unit returns zeros and raises a distinct error output, so the outcome is always deterministic.

Top module: `vunzip_unit`

## Requirements
- R1: In 128-bit mode (`quad_mode`=1), with the working value `{src_hi, src_lo}`, lane e of `res_even` equals element 2e of the working value, for e from 0 to 128/W−1, where W is the lane width.
- R2: Under the same conditions, lane e of `res_odd` equals element 2e+1 of the working value.
- R3: `lane_sz` code 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Lane e occupies bits [e·W+W−1 : e·W].
- R4: In 64-bit mode (`quad_mode`=0), the working value is `{src_hi[63:0], src_lo[63:0]}`. Lanes 0 to 64/W−1 of each result follow R1 and R2. Bits 127:64 of both inputs have no effect, and bits 127:64 of both results are zero.
- R5: When `same_reg`=1 on an accepted input, both results are zero and `same_reg_err` is 1. Otherwise `same_reg_err` is 0.
- R6: When `lane_sz`=2'b11 on an accepted input, both results are zero and `illegal_size` is 1. Otherwise `illegal_size` is 0. If both error conditions hold, both flags are raised.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock. The results and flags present while `out_valid` is 1 belong to the input accepted one cycle earlier. Back-to-back inputs are accepted on consecutive cycles.
- R8: In a cycle with `in_valid`=0, the results and both flags keep their previous values, whatever the other inputs carry.
- R9: While `rst_n` is low, `out_valid`, both results and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_lo | input | 128 | First operand, lower half of the working value |
| src_hi | input | 128 | Second operand, upper half of the working value |
| lane_sz | input | 2 | Lane width code (00=8, 01=16, 10=32, 11 reserved) |
| quad_mode | input | 1 | 1 = 128-bit registers, 0 = 64-bit registers |
| same_reg | input | 1 | Both operands name the same register |
| out_valid | output | 1 | Results valid |
| res_even | output | 128 | Even-indexed elements |
| res_odd | output | 128 | Odd-indexed elements |
| same_reg_err | output | 1 | Result forced to zero because the operands alias |
| illegal_size | output | 1 | Result forced to zero because the size code is reserved |

## Verification
The datapath has only one register stage. Any wrong lane routing, width selection or zero-forcing therefore shows at the result ports in the cycle right after the offending input, with no delayed symptom. A fault in a single lane width shows only for that size code. A fault in the 64-bit path shows only as non-zero upper bits or as stray upper-input bits reaching the low lanes. A bad valid register shows as `out_valid` out of step with `in_valid`. A missing hold enable shows as results changing across an idle cycle.

// File: rtl/vunzip_pkg.sv
package vunzip_pkg;

  typedef enum logic [1:0] {
    SZ_B8   = 2'b00,
    SZ_B16  = 2'b01,
    SZ_B32  = 2'b10,
    SZ_RSVD = 2'b11
  } lane_sz_e;

  localparam int NUM_SZ   = 3;
  localparam int BASE_LW  = 8;

  typedef struct packed {
    logic     alias_err;
    logic     size_err;
    logic     kill;
    lane_sz_e sel;
  } unzip_ctrl_t;

  function automatic int lane_bits(input int code);
    return BASE_LW << code;
  endfunction

endpackage

// File: rtl/vunzip_decode.sv
module vunzip_decode
  import vunzip_pkg::*;
(
  input  logic [1:0]  sz_i,
  input  logic        alias_i,
  output unzip_ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o.sel       = lane_sz_e'(sz_i);
    ctrl_o.size_err  = (lane_sz_e'(sz_i) == SZ_RSVD);
    ctrl_o.alias_err = alias_i;
    ctrl_o.kill      = ctrl_o.size_err | alias_i;
  end
endmodule

// File: rtl/vunzip_slice.sv
module vunzip_slice #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic [2*DATA_W-1:0] cat_i,
  output logic [DATA_W-1:0]   even_o,
  output logic [DATA_W-1:0]   odd_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar e = 0; e < NLANE; e++) begin : g_lane
    assign even_o[e*LANE_W +: LANE_W] = cat_i[(2*e)*LANE_W +: LANE_W];
    assign odd_o[e*LANE_W +: LANE_W]  = cat_i[(2*e+1)*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vunzip_unit.sv
module vunzip_unit
  import vunzip_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_lo,
  input  logic [DATA_W-1:0] src_hi,
  input  logic [1:0]        lane_sz,
  input  logic              quad_mode,
  input  logic              same_reg,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_even,
  output logic [DATA_W-1:0] res_odd,
  output logic              same_reg_err,
  output logic              illegal_size
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CAT_W  = 2 * DATA_W;

  // working value: in 64-bit mode the upper inputs are dropped and the
  // top half is zero, so upper result lanes fall out as zero.
  function automatic logic [CAT_W-1:0] form_pair(
    input logic [DATA_W-1:0] lo,
    input logic [DATA_W-1:0] hi,
    input logic              quad
  );
    if (quad) return {hi, lo};
    return {{DATA_W{1'b0}}, hi[HALF_W-1:0], lo[HALF_W-1:0]};
  endfunction

  unzip_ctrl_t        ctrl_w;
  logic [CAT_W-1:0]   cat_w;
  logic [DATA_W-1:0]  ev_arr [NUM_SZ];
  logic [DATA_W-1:0]  od_arr [NUM_SZ];
  logic [DATA_W-1:0]  ev_sel_w, od_sel_w;
  logic               accept_w;
  logic               kill_w;

  vunzip_decode u_dec (
    .sz_i    (lane_sz),
    .alias_i (same_reg),
    .ctrl_o  (ctrl_w)
  );

  assign cat_w    = form_pair(src_lo, src_hi, quad_mode);
  assign accept_w = in_valid;
  assign kill_w   = ctrl_w.kill;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    vunzip_slice #(
      .DATA_W (DATA_W),
      .LANE_W (lane_bits(k))
    ) u_slice (
      .cat_i  (cat_w),
      .even_o (ev_arr[k]),
      .odd_o  (od_arr[k])
    );
  end

  always_comb begin
    ev_sel_w = '0;
    od_sel_w = '0;
    if (!kill_w) begin
      case (ctrl_w.sel)
        SZ_B8:   begin ev_sel_w = ev_arr[0]; od_sel_w = od_arr[0]; end
        SZ_B16:  begin ev_sel_w = ev_arr[1]; od_sel_w = od_arr[1]; end
        SZ_B32:  begin ev_sel_w = ev_arr[2]; od_sel_w = od_arr[2]; end
        default: begin ev_sel_w = '0;        od_sel_w = '0;        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= accept_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_even     <= '0;
      res_odd      <= '0;
      same_reg_err <= 1'b0;
      illegal_size <= 1'b0;
    end else if (accept_w) begin
      res_even     <= ev_sel_w;
      res_odd      <= od_sel_w;
      same_reg_err <= ctrl_w.alias_err;
      illegal_size <= ctrl_w.size_err;
    end
  end
endmodule

// File: rtl/vunzip_chk.sv
module vunzip_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept_w,
  input logic              kill_w,
  input logic [1:0]        lane_sz,
  input logic              quad_mode,
  input logic              same_reg,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_even,
  input logic [DATA_W-1:0] res_odd,
  input logic              same_reg_err,
  input logic              illegal_size
);
  localparam int HALF_W = DATA_W / 2;

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> out_valid);

  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> !out_valid);

  assert_alias_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && same_reg |=> same_reg_err && res_even == '0 && res_odd == '0);

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && lane_sz == 2'b11 |=> illegal_size && res_even == '0 && res_odd == '0);

  assert_kill_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !kill_w |=> !same_reg_err && !illegal_size);

  assert_double_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !quad_mode |=> res_even[DATA_W-1:HALF_W] == '0 && res_odd[DATA_W-1:HALF_W] == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(res_even) && $stable(res_odd) && $stable(same_reg_err) && $stable(illegal_size));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid && res_even == '0 && res_odd == '0);
endmodule

bind vunzip_unit vunzip_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept_w     (accept_w),
  .kill_w       (kill_w),
  .lane_sz      (lane_sz),
  .quad_mode    (quad_mode),
  .same_reg     (same_reg),
  .out_valid    (out_valid),
  .res_even     (res_even),
  .res_odd      (res_odd),
  .same_reg_err (same_reg_err),
  .illegal_size (illegal_size)
);

// File: tb/vunzip_unit_tb_top.sv
module vunzip_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_lo = '0, src_hi = '0;
  logic [1:0]   lane_sz = 2'b00;
  logic         quad_mode = 1'b0;
  logic         same_reg = 1'b0;
  logic         out_valid;
  logic [127:0] res_even, res_odd;
  logic         same_reg_err, illegal_size;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  vunzip_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_lo(src_lo), .src_hi(src_hi), .lane_sz(lane_sz),
    .quad_mode(quad_mode), .same_reg(same_reg),
    .out_valid(out_valid), .res_even(res_even), .res_odd(res_odd),
    .same_reg_err(same_reg_err), .illegal_size(illegal_size)
  );

  logic [127:0] exp_ev, exp_od;
  logic         exp_se, exp_il;

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // reference: walks bits of each element of the joined pair
  task automatic model(input logic [127:0] lo, input logic [127:0] hi,
                       input logic [1:0] sz, input logic q, input logic s);
    logic [255:0] pair;
    int w, n;
    exp_ev = '0; exp_od = '0;
    exp_se = s;
    exp_il = (sz == 2'b11);
    if (s || sz == 2'b11) return;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    pair = q ? {hi, lo} : {128'b0, hi[63:0], lo[63:0]};
    n = (q ? 128 : 64) / w;
    for (int e = 0; e < n; e++)
      for (int b = 0; b < w; b++) begin
        exp_ev[e*w+b] = pair[2*e*w+b];
        exp_od[e*w+b] = pair[(2*e+1)*w+b];
      end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives one op, checks it at the next negedge
  task automatic op(input string req, input logic [127:0] lo, input logic [127:0] hi,
                    input logic [1:0] sz, input logic q, input logic s);
    in_valid = 1'b1; src_lo = lo; src_hi = hi; lane_sz = sz; quad_mode = q; same_reg = s;
    model(lo, hi, sz, q, s);
    @(negedge clk);
    chk("R7", "out_valid", {127'b0, out_valid}, 128'd1);
    chk(req, "res_even", res_even, exp_ev);
    chk(req, "res_odd", res_odd, exp_od);
    chk(req, "flags", {126'b0, same_reg_err, illegal_size}, {126'b0, exp_se, exp_il});
  endtask

  task automatic idle();
    logic [127:0] pe, po;
    logic [1:0]   pf;
    pe = res_even; po = res_odd; pf = {same_reg_err, illegal_size};
    in_valid = 1'b0; src_lo = rnd128(); src_hi = rnd128();
    lane_sz = 2'($urandom); quad_mode = 1'($urandom); same_reg = 1'($urandom);
    @(negedge clk);
    chk("R7", "out_valid idle", {127'b0, out_valid}, 128'd0);
    chk("R8", "hold even", res_even, pe);
    chk("R8", "hold odd", res_odd, po);
    chk("R8", "hold flags", {126'b0, same_reg_err, illegal_size}, {126'b0, pf});
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] ramp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(i);
    repeat (3) @(negedge clk);
    in_valid = 1'b1;  // must not matter during reset
    @(negedge clk);
    chk("R9", "reset out_valid", {127'b0, out_valid}, 128'd0);
    chk("R9", "reset even", res_even, '0);
    chk("R9", "reset odd", res_odd, '0);
    chk("R9", "reset flags", {126'b0, same_reg_err, illegal_size}, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // directed: quad mode, each lane width (R1, R2, R3)
    op("R1", ramp, ~ramp, 2'b00, 1'b1, 1'b0);
    op("R2", ramp, ~ramp, 2'b01, 1'b1, 1'b0);
    op("R3", ramp, ~ramp, 2'b10, 1'b1, 1'b0);
    idle();
    // double mode with junk in upper halves (R4)
    op("R4", {64'hDEAD_BEEF_CAFE_F00D, ramp[63:0]}, {64'hFFFF_FFFF_FFFF_FFFF, ramp[127:64]}, 2'b00, 1'b0, 1'b0);
    op("R4", {64'h1234_5678_9ABC_DEF0, ramp[63:0]}, ~ramp, 2'b10, 1'b0, 1'b0);
    // aliasing and reserved size (R5, R6)
    op("R5", ramp, ~ramp, 2'b01, 1'b1, 1'b1);
    op("R6", ramp, ~ramp, 2'b11, 1'b1, 1'b0);
    op("R6", ramp, ~ramp, 2'b11, 1'b0, 1'b1);
    op("R1", ramp, ~ramp, 2'b00, 1'b1, 1'b0);   // flags clear again
    idle();
    idle();

    // constrained random, mixing back-to-back and idle cycles
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz;
      sz = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      op("R7", rnd128(), rnd128(), sz, 1'($urandom), ($urandom % 10 == 0));
      if ($urandom % 4 == 0) idle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule